// File: doc/BRIEF.md
# Configurable CPLD Macrocell

This block models one macrocell of a complex programmable logic device. A 21-bit configuration word sets what the cell does. It holds a 4-entry truth table that is indexed by two data inputs. It selects one clock from eight sources, can invert that clock, and selects the clock-enable, set and reset sources. A 2-bit field sets the storage mode: D flip-flop, toggle flip-flop, transparent latch, or D flip-flop with clock enable. Further fields choose where the register's D input comes from and which value goes to the routing fabric.

When the parameter `HAS_PAD` is set, a pad section is added. A separate 6-bit word configures it: slew, output-enable source, the value driven to the pad, and the value the pad returns to the routing fabric.

The model runs on a fast sampling clock `clk`. Every input is sampled on each rising edge of `clk`. An edge of the selected cell clock is a sample in which the selected (and possibly inverted) level is 1 while the previous sample was 0. Set and reset act on the next sample no matter what the cell clock is doing. Reset has priority over set.

Top module: `cpld_cell`

## Requirements
- R1: While `rst_n` is low, the register output `q_out` is 0. The sampled previous clock level is also cleared to 0.
- R2: The truth table sits in `cfg_word[4:1]`. The combinational output is `cfg_word[1 + {lut_b, lut_a}]`. When `cfg_word[0]` is 1, `route_out` carries it in the same cycle; when it is 0, `route_out` carries `q_out`.
- R3: Mode `cfg_word[20:19]` = 00 is a D flip-flop. `q_out` takes D at the first `clk` edge where the selected clock level is 1 after a sample where it was 0. It holds at every other edge.
- R4: The clock select is `cfg_word[18:16]`: 000 = `bclk[0]`, 001 = `bclk[1]`, 010 = `pt_clk`, 011/100/101/110 = `lct[4]`/`lct[5]`/`lct[6]`/`lct[7]`, 111 = `uct[3]`. When `cfg_word[15]` is 1, the selected source is inverted, so the falling edge of the source captures D.
- R5: Mode 01 is a toggle flip-flop. On a clock edge with D = 1, `q_out` inverts. With D = 0, it holds.
- R6: Mode 10 is a latch. `q_out` follows D at every `clk` edge while the selected clock level is 1. It holds while that level is 0.
- R7: Mode 11 is a D flip-flop with enable. It captures D on a clock edge only when the enable is 1. The enable is `lct[4]` when `cfg_word[14]` is 0 and `pt_clk` when it is 1.
- R8: The set select is `cfg_word[13:11]` and the reset select is `cfg_word[10:8]`. In both, 000 to 101 pick `lct[0]` to `lct[5]` and 111 means never. For 110, set uses `uct[2]` and reset uses `uct[1]`. An active reset forces `q_out` to 0 and an active set forces it to 1 at the next `clk` edge. Reset wins when both are active.
- R9: D is chosen as follows. When `cfg_word[7]` = 1 (shift mode), D is `shift_up_in` if `cfg_word[6]` = 0 and `shift_dn_in` if it is 1. Otherwise, D is `pad_in` when `cfg_word[5]` = 1 and the truth-table output when it is 0.
- R10: The output-enable select is `pad_cfg[4:2]`. 000 gives `pad_oe` = 0. 001/010/011 give `lct[0]`/`lct[1]`/`lct[2]`. 100 gives `lct[6]`. 101 gives `uct[0]`. 110 gives 1. 111 gives `pad_oe` = 0 with `pad_pullup` = 1. `pad_oe` and `pad_pullup` are never both 1.
- R11: `pad_o` is `q_out` when `pad_cfg[1]` = 0 and the truth-table output when it is 1. `pad_fb_out` is `q_out` when `pad_cfg[0]` = 0 and `pad_in` when it is 1. `pad_slow` follows `pad_cfg[5]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock of the model |
| rst_n | input | 1 | Active-low reset |
| cfg_word | input | 21 | Cell configuration word |
| pad_cfg | input | 6 | Pad configuration word |
| lut_a | input | 1 | Truth-table index bit 0 |
| lut_b | input | 1 | Truth-table index bit 1 |
| lct | input | 8 | Local control terms |
| uct | input | 4 | Universal control terms |
| bclk | input | 2 | Block clocks |
| pt_clk | input | 1 | Per-cell product-term clock and enable |
| pad_in | input | 1 | Input buffer value from the pad |
| shift_up_in | input | 1 | Register value of the upper neighbour |
| shift_dn_in | input | 1 | Register value of the lower neighbour |
| q_out | output | 1 | Register output |
| route_out | output | 1 | Cell output to routing |
| pad_fb_out | output | 1 | Pad-side output to routing |
| pad_o | output | 1 | Value driven toward the pad |
| pad_oe | output | 1 | Pad output enable |
| pad_pullup | output | 1 | Weak pull-up request |
| pad_slow | output | 1 | Slow slew select |

## Verification
The truth-table output, `route_out` and the pad outputs are combinational. They are due in the cycle the inputs change, so the bench drives on the falling edge of `clk` and samples one time unit later. Register results come through one register. They are due right after the first rising edge of `clk` that samples the triggering condition: a new clock level, set, reset or latch-open. The bench changes stimulus on a falling edge, lets one rising edge pass, and checks on the next falling edge. Before a clock select or inversion is changed, every clock source is parked in a known state, so no edge appears by accident.

// File: rtl/cell_pkg.sv
package cell_pkg;

  localparam int LCT_N    = 8;
  localparam int UCT_N    = 4;
  localparam int LUT_W    = 4;
  localparam int SEL_W    = 3;
  localparam int CFG_W    = 21;
  localparam int PCFG_W   = 6;
  localparam int OESRC_W  = 5;

  typedef enum logic [1:0] {
    MODE_DFF   = 2'b00,
    MODE_TFF   = 2'b01,
    MODE_LATCH = 2'b10,
    MODE_DFFCE = 2'b11
  } reg_mode_e;

  typedef struct packed {
    reg_mode_e        mode;
    logic [SEL_W-1:0] clk_sel;
    logic             clk_inv;
    logic             ce_sel;
    logic [SEL_W-1:0] set_sel;
    logic [SEL_W-1:0] rst_sel;
    logic             shift_en;
    logic             shift_dir;
    logic             ireg_d;
    logic [LUT_W-1:0] lut;
    logic             route_sel;
  } cell_cfg_t;

  typedef struct packed {
    logic             slow;
    logic [SEL_W-1:0] oe_sel;
    logic             pad_sel;
    logic             fb_sel;
  } pad_cfg_t;

  function automatic logic lut_eval(input logic [LUT_W-1:0] tt,
                                    input logic a, input logic b);
    return tt[{b, a}];
  endfunction

  function automatic logic pick_clk(input logic [SEL_W-1:0] sel,
                                    input logic [1:0] bclk, input logic pt,
                                    input logic [LCT_N-1:0] lct, input logic uct3);
    case (sel)
      3'd0:    return bclk[0];
      3'd1:    return bclk[1];
      3'd2:    return pt;
      3'd3:    return lct[4];
      3'd4:    return lct[5];
      3'd5:    return lct[6];
      3'd6:    return lct[7];
      default: return uct3;
    endcase
  endfunction

  function automatic logic pick_ctl(input logic [SEL_W-1:0] sel,
                                    input logic [LCT_N-1:0] lct, input logic alt);
    case (sel)
      3'd6:    return alt;
      3'd7:    return 1'b0;
      default: return lct[sel];
    endcase
  endfunction

  // src = {uct0, lct6, lct2, lct1, lct0}; result = {oe, pullup}
  function automatic logic [1:0] pick_oe(input logic [SEL_W-1:0] sel,
                                         input logic [OESRC_W-1:0] src);
    case (sel)
      3'd0:    return 2'b00;
      3'd1:    return {src[0], 1'b0};
      3'd2:    return {src[1], 1'b0};
      3'd3:    return {src[2], 1'b0};
      3'd4:    return {src[3], 1'b0};
      3'd5:    return {src[4], 1'b0};
      3'd6:    return 2'b10;
      default: return 2'b01;
    endcase
  endfunction

  function automatic logic next_q(input reg_mode_e mode, input logic q,
                                  input logic d, input logic rise,
                                  input logic lvl, input logic ce);
    case (mode)
      MODE_DFF:   return rise ? d : q;
      MODE_TFF:   return (rise && d) ? ~q : q;
      MODE_LATCH: return lvl ? d : q;
      default:    return (rise && ce) ? d : q;
    endcase
  endfunction

endpackage

// File: rtl/cell_ctrl.sv
module cell_ctrl
  import cell_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  cell_cfg_t        cfg,
  input  logic [1:0]       bclk,
  input  logic             pt_clk,
  input  logic [LCT_N-1:0] lct,
  input  logic             uct_clk,
  input  logic             uct_set,
  input  logic             uct_rst,
  output logic             clk_lvl,
  output logic             clk_rise,
  output logic             ce_on,
  output logic             set_on,
  output logic             rst_on
);

  logic clk_prev;

  assign clk_lvl  = pick_clk(cfg.clk_sel, bclk, pt_clk, lct, uct_clk) ^ cfg.clk_inv;
  assign clk_rise = clk_lvl & ~clk_prev;
  assign ce_on    = cfg.ce_sel ? pt_clk : lct[4];
  assign set_on   = pick_ctl(cfg.set_sel, lct, uct_set);
  assign rst_on   = pick_ctl(cfg.rst_sel, lct, uct_rst);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) clk_prev <= 1'b0;
    else        clk_prev <= clk_lvl;
  end

  // two detected edges need a low sample between them
  assert_no_double_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
    clk_rise |=> !clk_rise);

endmodule

// File: rtl/cell_store.sv
module cell_store
  import cell_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  reg_mode_e mode,
  input  logic      d,
  input  logic      clk_lvl,
  input  logic      clk_rise,
  input  logic      ce_on,
  input  logic      set_on,
  input  logic      rst_on,
  output logic      q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q <= 1'b0;
    else if (rst_on) q <= 1'b0;
    else if (set_on) q <= 1'b1;
    else             q <= next_q(mode, q, d, clk_rise, clk_lvl, ce_on);
  end

  assert_rst_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rst_on |=> !q);

  assert_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (set_on && !rst_on) |=> q);

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!rst_on && !set_on && !clk_rise && !(mode == MODE_LATCH && clk_lvl)) |=> $stable(q));

  assert_toggle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!rst_on && !set_on && clk_rise && mode == MODE_TFF && d) |=> (q != $past(q)));

endmodule

// File: rtl/cell_pad.sv
module cell_pad
  import cell_pkg::*;
(
  input  pad_cfg_t           pcfg,
  input  logic               q,
  input  logic               lut_out,
  input  logic               pad_in,
  input  logic [OESRC_W-1:0] oe_src,
  output logic               pad_o,
  output logic               pad_oe,
  output logic               pad_pullup,
  output logic               pad_slow,
  output logic               pad_fb_out
);

  logic [1:0] oe_pair;

  assign oe_pair    = pick_oe(pcfg.oe_sel, oe_src);
  assign pad_oe     = oe_pair[1];
  assign pad_pullup = oe_pair[0];
  assign pad_o      = pcfg.pad_sel ? lut_out : q;
  assign pad_fb_out = pcfg.fb_sel ? pad_in : q;
  assign pad_slow   = pcfg.slow;

endmodule

// File: rtl/cpld_cell.sv
module cpld_cell
  import cell_pkg::*;
#(
  parameter bit HAS_PAD = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CFG_W-1:0]  cfg_word,
  input  logic [PCFG_W-1:0] pad_cfg,
  input  logic              lut_a,
  input  logic              lut_b,
  input  logic [LCT_N-1:0]  lct,
  input  logic [UCT_N-1:0]  uct,
  input  logic [1:0]        bclk,
  input  logic              pt_clk,
  input  logic              pad_in,
  input  logic              shift_up_in,
  input  logic              shift_dn_in,
  output logic              q_out,
  output logic              route_out,
  output logic              pad_fb_out,
  output logic              pad_o,
  output logic              pad_oe,
  output logic              pad_pullup,
  output logic              pad_slow
);

  cell_cfg_t cfg;
  logic      lut_out;
  logic      d_in;
  logic      clk_lvl, clk_rise, ce_on, set_on, rst_on;

  assign cfg     = cfg_word;
  assign lut_out = lut_eval(cfg.lut, lut_a, lut_b);

  always_comb begin
    if (cfg.shift_en)    d_in = cfg.shift_dir ? shift_dn_in : shift_up_in;
    else if (cfg.ireg_d) d_in = pad_in;
    else                 d_in = lut_out;
  end

  cell_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg      (cfg),
    .bclk     (bclk),
    .pt_clk   (pt_clk),
    .lct      (lct),
    .uct_clk  (uct[3]),
    .uct_set  (uct[2]),
    .uct_rst  (uct[1]),
    .clk_lvl  (clk_lvl),
    .clk_rise (clk_rise),
    .ce_on    (ce_on),
    .set_on   (set_on),
    .rst_on   (rst_on)
  );

  cell_store u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode     (cfg.mode),
    .d        (d_in),
    .clk_lvl  (clk_lvl),
    .clk_rise (clk_rise),
    .ce_on    (ce_on),
    .set_on   (set_on),
    .rst_on   (rst_on),
    .q        (q_out)
  );

  assign route_out = cfg.route_sel ? lut_out : q_out;

  generate
    if (HAS_PAD) begin : g_pad
      cell_pad u_pad (
        .pcfg       (pad_cfg_t'(pad_cfg)),
        .q          (q_out),
        .lut_out    (lut_out),
        .pad_in     (pad_in),
        .oe_src     ({uct[0], lct[6], lct[2:0]}),
        .pad_o      (pad_o),
        .pad_oe     (pad_oe),
        .pad_pullup (pad_pullup),
        .pad_slow   (pad_slow),
        .pad_fb_out (pad_fb_out)
      );
    end else begin : g_nopad
      assign pad_o      = 1'b0;
      assign pad_oe     = 1'b0;
      assign pad_pullup = 1'b0;
      assign pad_slow   = 1'b0;
      assign pad_fb_out = 1'b0;
    end
  endgenerate

  assert_oe_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(pad_oe && pad_pullup));

endmodule

// File: tb/sim_cpld_cell.sv
module sim_cpld_cell;

  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [3:0] tt;
    logic [1:0] ba;
    logic [2:0] oe;
    logic [7:0] lcv;
    logic [3:0] ucv;
    logic       e_lut;
    logic       e_oe;
    logic       e_pu;
  } vec_t;

  localparam vec_t VECS [10] = '{
    '{4'b0110, 2'b00, 3'b000, 8'h00, 4'h0, 1'b0, 1'b0, 1'b0},
    '{4'b0110, 2'b01, 3'b001, 8'h01, 4'h0, 1'b1, 1'b1, 1'b0},
    '{4'b0110, 2'b10, 3'b010, 8'h01, 4'h0, 1'b1, 1'b0, 1'b0},
    '{4'b0110, 2'b11, 3'b011, 8'h04, 4'h0, 1'b0, 1'b1, 1'b0},
    '{4'b1000, 2'b11, 3'b100, 8'h40, 4'h0, 1'b1, 1'b1, 1'b0},
    '{4'b1000, 2'b10, 3'b100, 8'hBF, 4'h0, 1'b0, 1'b0, 1'b0},
    '{4'b0001, 2'b00, 3'b101, 8'h00, 4'h1, 1'b1, 1'b1, 1'b0},
    '{4'b0001, 2'b01, 3'b101, 8'h00, 4'hE, 1'b0, 1'b0, 1'b0},
    '{4'b0100, 2'b10, 3'b110, 8'h00, 4'h0, 1'b1, 1'b1, 1'b0},
    '{4'b0010, 2'b01, 3'b111, 8'h00, 4'h0, 1'b1, 1'b0, 1'b1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] m_mode = 2'b00;
  logic [2:0] m_clk = 3'b000;
  logic m_inv = 1'b0, m_ce = 1'b0;
  logic [2:0] m_set = 3'b111, m_rst = 3'b111;
  logic m_sh = 1'b0, m_dir = 1'b0, m_ireg = 1'b0;
  logic [3:0] m_lut = 4'b0000;
  logic m_route = 1'b0;
  logic p_slow = 1'b0;
  logic [2:0] p_oe = 3'b000;
  logic p_psel = 1'b0, p_fsel = 1'b0;
  logic lut_a = 1'b0, lut_b = 1'b0;
  logic [7:0] lct = 8'h00;
  logic [3:0] uct = 4'h0;
  logic [1:0] bclk = 2'b00;
  logic pt_clk = 1'b0, pad_in = 1'b0, shift_up_in = 1'b0, shift_dn_in = 1'b0;

  logic [20:0] cfg_word;
  logic [5:0]  pad_cfg;
  logic q_out, route_out, pad_fb_out, pad_o, pad_oe, pad_pullup, pad_slow;

  int checks = 0;
  int failures = 0;

  assign cfg_word = {m_mode, m_clk, m_inv, m_ce, m_set, m_rst, m_sh, m_dir, m_ireg, m_lut, m_route};
  assign pad_cfg  = {p_slow, p_oe, p_psel, p_fsel};

  always #(CLK_PERIOD/2) clk = ~clk;

  cpld_cell u0 (
    .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word), .pad_cfg(pad_cfg),
    .lut_a(lut_a), .lut_b(lut_b), .lct(lct), .uct(uct), .bclk(bclk),
    .pt_clk(pt_clk), .pad_in(pad_in), .shift_up_in(shift_up_in),
    .shift_dn_in(shift_dn_in), .q_out(q_out), .route_out(route_out),
    .pad_fb_out(pad_fb_out), .pad_o(pad_o), .pad_oe(pad_oe),
    .pad_pullup(pad_pullup), .pad_slow(pad_slow)
  );

  task automatic check(input string tag, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%0b exp=%0b at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic drive_src(input int code, input logic v);
    case (code)
      0: bclk[0] = v;
      1: bclk[1] = v;
      2: pt_clk = v;
      3: lct[4] = v;
      4: lct[5] = v;
      5: lct[6] = v;
      6: lct[7] = v;
      default: uct[3] = v;
    endcase
  endtask

  task automatic drive_ctl(input int code, input bit is_set, input logic v);
    if (code < 6) lct[code] = v;
    else if (code == 6) begin
      if (is_set) uct[2] = v;
      else        uct[1] = v;
    end
  endtask

  task automatic edge0(input logic [3:0] tt);
    m_lut = tt;
    bclk[0] = 1'b1;
    step();
  endtask

  task automatic fall0();
    bclk[0] = 1'b0;
    step();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // R1 reset state
    @(negedge clk);
    bclk = 2'b11;
    m_lut = 4'b1111;
    step();
    check("R1 q in reset", q_out, 1'b0);
    check("R1 route in reset", route_out, 1'b0);
    bclk = 2'b00;
    step();
    rst_n = 1'b1;
    step();
    check("R1 q after release", q_out, 1'b0);

    // R2 / R10 / R11 table walk (combinational)
    m_route = 1'b1;
    p_psel = 1'b1;
    for (int i = 0; i < 10; i++) begin
      m_lut = VECS[i].tt;
      {lut_b, lut_a} = VECS[i].ba;
      p_oe = VECS[i].oe;
      lct = VECS[i].lcv;
      uct = VECS[i].ucv;
      #1;
      check("R2 route_out table", route_out, VECS[i].e_lut);
      check("R11 pad_o table", pad_o, VECS[i].e_lut);
      check("R10 pad_oe table", pad_oe, VECS[i].e_oe);
      check("R10 pad_pullup table", pad_pullup, VECS[i].e_pu);
      @(negedge clk);
    end
    lct = 8'h00;
    uct = 4'h0;
    m_route = 1'b0;
    {lut_b, lut_a} = 2'b00;
    step();

    // R3 / R4 clock select, DFF mode
    m_mode = 2'b00;
    for (int c = 0; c < 8; c++) begin
      m_clk = 3'(c);
      step();
      step();
      m_lut = 4'b1111;
      drive_src(c, 1'b1);
      step();
      check("R4 capture on rise", q_out, 1'b1);
      drive_src(c, 1'b0);
      m_lut = 4'b0000;
      step();
      check("R3 hold on fall", q_out, 1'b1);
      check("R3 route shows q", route_out, 1'b1);
      drive_src(c, 1'b1);
      step();
      check("R4 capture second rise", q_out, 1'b0);
      drive_src(c, 1'b0);
      step();
    end

    // R4 inversion on bclk[1]
    m_clk = 3'd1;
    m_inv = 1'b1;
    bclk[1] = 1'b1;
    step();
    step();
    m_lut = 4'b1111;
    bclk[1] = 1'b0;
    step();
    check("R4 inverted capture on source fall", q_out, 1'b1);
    m_lut = 4'b0000;
    bclk[1] = 1'b1;
    step();
    check("R4 inverted hold on source rise", q_out, 1'b1);
    bclk[1] = 1'b0;
    step();
    check("R4 inverted second capture", q_out, 1'b0);
    bclk[1] = 1'b0;
    m_inv = 1'b0;
    m_clk = 3'd0;
    step();

    // R5 toggle
    m_mode = 2'b01;
    step();
    edge0(4'b1111);
    check("R5 toggle to 1", q_out, 1'b1);
    fall0();
    edge0(4'b0000);
    check("R5 hold with D=0", q_out, 1'b1);
    fall0();
    edge0(4'b1111);
    check("R5 toggle to 0", q_out, 1'b0);
    fall0();

    // R6 latch
    m_mode = 2'b10;
    edge0(4'b1111);
    check("R6 transparent 1", q_out, 1'b1);
    m_lut = 4'b0000;
    step();
    check("R6 transparent 0", q_out, 1'b0);
    m_lut = 4'b1111;
    step();
    check("R6 transparent 1 again", q_out, 1'b1);
    bclk[0] = 1'b0;
    step();
    m_lut = 4'b0000;
    step();
    check("R6 closed holds", q_out, 1'b1);

    // R7 DFF with enable
    m_mode = 2'b11;
    m_ce = 1'b0;
    lct[4] = 1'b0;
    step();
    edge0(4'b0000);
    check("R7 disabled holds", q_out, 1'b1);
    fall0();
    lct[4] = 1'b1;
    edge0(4'b0000);
    check("R7 lct4 enable captures", q_out, 1'b0);
    fall0();
    lct[4] = 1'b0;
    m_ce = 1'b1;
    pt_clk = 1'b0;
    step();
    edge0(4'b1111);
    check("R7 pt enable low holds", q_out, 1'b0);
    fall0();
    pt_clk = 1'b1;
    edge0(4'b1111);
    check("R7 pt enable captures", q_out, 1'b1);
    fall0();
    pt_clk = 1'b0;
    m_ce = 1'b0;

    // R8 set / reset selects
    m_mode = 2'b00;
    m_lut = 4'b0000;
    step();
    for (int s = 0; s < 7; s++) begin
      m_set = 3'(s);
      m_rst = 3'd7;
      drive_ctl(s, 1'b1, 1'b1);
      step();
      check("R8 set source", q_out, 1'b1);
      drive_ctl(s, 1'b1, 1'b0);
      m_set = 3'd7;
      m_rst = 3'(s);
      step();
      drive_ctl(s, 1'b0, 1'b1);
      step();
      check("R8 reset source", q_out, 1'b0);
      drive_ctl(s, 1'b0, 1'b0);
      m_rst = 3'd7;
      step();
    end
    lct = 8'hFF;
    uct = 4'hF;
    step();
    check("R8 ground never sets", q_out, 1'b0);
    lct = 8'h00;
    uct = 4'h0;
    m_set = 3'd0;
    lct[0] = 1'b1;
    step();
    lct[0] = 1'b0;
    m_set = 3'd7;
    step();
    lct = 8'hFF;
    uct = 4'hF;
    step();
    check("R8 ground never resets", q_out, 1'b1);
    lct = 8'h00;
    uct = 4'h0;
    m_set = 3'd2;
    m_rst = 3'd2;
    lct[2] = 1'b1;
    step();
    check("R8 reset beats set", q_out, 1'b0);
    lct[2] = 1'b0;
    m_set = 3'd7;
    m_rst = 3'd7;
    step();

    // R9 D source
    m_sh = 1'b1;
    m_dir = 1'b0;
    shift_up_in = 1'b1;
    shift_dn_in = 1'b0;
    pad_in = 1'b0;
    edge0(4'b0000);
    check("R9 shift up source", q_out, 1'b1);
    fall0();
    m_dir = 1'b1;
    edge0(4'b0000);
    check("R9 shift down source", q_out, 1'b0);
    fall0();
    m_sh = 1'b0;
    m_ireg = 1'b1;
    pad_in = 1'b1;
    edge0(4'b0000);
    check("R9 input register path", q_out, 1'b1);
    fall0();
    m_ireg = 1'b0;
    edge0(4'b0000);
    check("R9 table path", q_out, 1'b0);
    fall0();

    // R11 pad muxes
    edge0(4'b1111);
    fall0();
    m_lut = 4'b0000;
    m_route = 1'b0;
    p_psel = 1'b0;
    p_fsel = 1'b0;
    pad_in = 1'b0;
    #1;
    check("R2 route selects q", route_out, 1'b1);
    check("R11 pad_o selects q", pad_o, 1'b1);
    check("R11 pad_fb selects q", pad_fb_out, 1'b1);
    p_psel = 1'b1;
    p_fsel = 1'b1;
    #1;
    check("R11 pad_o selects table", pad_o, 1'b0);
    check("R11 pad_fb selects pad_in", pad_fb_out, 1'b0);
    p_slow = 1'b1;
    #1;
    check("R11 slow slew", pad_slow, 1'b1);
    p_slow = 1'b0;
    #1;
    check("R11 fast slew", pad_slow, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule